// File: doc/BRIEF.md
# Write-Permission Guard for a Serial Nonvolatile Memory

This block decides whether a write request arriving from the serial command decoder of a small byte-wide nonvolatile memory may go ahead. It holds a write-enable latch and a two-bit protect-range field. The decoder sends it one-cycle pulses: enable, disable, status-register write (with its data byte), memory-byte write (with its address) and end of frame, which is the chip-select rising edge. The block returns a grant for each write request in the same cycle. It also returns the status byte that a status read shifts out.

Writes are gated in tiers. The latch must be set. The active-low protect pin must be high. For memory writes, the address must also lie outside the range that the protect field selects. The latch clears itself when a frame that carried a write request ends. A status write changes only the protect field. The protect field stands in for nonvolatile storage and is a plain register.

Top module: `status_wr_guard`

## Requirements
- R1: After reset the status byte reads 0x00: the latch is clear and the protect field is 00.
- R2: An enable pulse sets the latch, which reads back at status bit 1. A disable pulse clears it. When both arrive in the same cycle, the disable wins.
- R3: Status bits 7..4 and bit 0 always read 0, even after a status write whose data has ones in those positions. Bits 3..2 read the protect field.
- R4: While the latch is clear, every memory write and status write is refused, and the protect field is left unchanged.
- R5: While `wp_n_i` is low, every memory write and status write is refused, whatever the latch holds.
- R6: A granted status write loads data bits 3..2 into the protect field. It does not change the latch.
- R7: An end-of-frame pulse clears the latch when the frame held a memory-write or status-write request, granted or not. The request may arrive in the same cycle as the pulse. An end of frame with no write request leaves the latch set.
- R8: The protect codes are 00 for no range, 01 for the top quarter of the address space (0x180–0x1FF), 10 for the top half (0x100–0x1FF) and 11 for the whole space. A memory write into the selected range is refused.
- R9: With the latch set and the pin high, a memory write outside the protected range is granted. A refused byte does not end the frame: later bytes of the same burst are judged one by one, including across the wrap from 0x1FF to 0x000.
- R10: Grants are computed in the same cycle from the current register state. A write request in the same cycle as an enable pulse is judged against the latch value from before that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_en_i | input | 1 | Pulse that sets the write-enable latch |
| clr_en_i | input | 1 | Pulse that clears the write-enable latch |
| sr_wr_i | input | 1 | Status-register write request |
| sr_data_i | input | 8 | Data byte of the status write |
| mem_wr_i | input | 1 | Memory-byte write request |
| mem_addr_i | input | 9 | Address of the memory byte |
| wp_n_i | input | 1 | Write-protect pin, active low |
| frame_end_i | input | 1 | End-of-frame pulse (chip-select rise) |
| mem_grant_o | output | 1 | Memory write may proceed |
| sr_grant_o | output | 1 | Status write may proceed |
| status_o | output | 8 | Status byte as read back |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both on purpose. In the first, an enable pulse arrives with a memory-write request; the grant must follow the old latch value and be refused. In the second, a final write request arrives together with the end-of-frame pulse; the latch must still clear. The bench also drives an enable and a disable pulse in one cycle. Each case is judged against a behavioural reference model in the bench, which predicts both grants and the status byte on every clock.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  localparam int STAT_W  = 8;
  localparam int BP_W    = 2;
  localparam int WEL_POS = 1;
  localparam int BP_LSB  = 2;
  localparam int BP_MSB  = BP_LSB + BP_W - 1;

  typedef enum logic [BP_W-1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_code_e;
endpackage

// File: rtl/wrg_enable_latch.sv
module wrg_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_req_i,
  input  logic frame_end_i,
  output logic wel_o
);
  logic wel_q;
  logic seen_q;
  logic frame_had_wr;

  // a write in this frame, including one arriving with the end pulse
  assign frame_had_wr = seen_q | wr_req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (frame_end_i && frame_had_wr) wel_q <= 1'b0;
      else if (clr_i)                  wel_q <= 1'b0;
      else if (set_i)                  wel_q <= 1'b1;
      seen_q <= frame_end_i ? 1'b0 : frame_had_wr;
    end
  end

  assign wel_o = wel_q;

  // R7
  wel_drop_after_write_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end_i && frame_had_wr) |=> !wel_q);

  // R2
  wel_rise_needs_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wel_q) |-> ($past(set_i) && !$past(clr_i)));
endmodule

// File: rtl/wrg_range_check.sv
module wrg_range_check
  import wrg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  prot_code_e        code_i,
  output logic              hit_o
);
  localparam int unsigned DEPTH     = 1 << ADDR_W;
  localparam int unsigned HALF_BASE = DEPTH / 2;
  localparam int unsigned QTR_BASE  = DEPTH - DEPTH / 4;

  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr_i);

  always_comb begin
    unique case (code_i)
      PROT_NONE: hit_o = 1'b0;
      PROT_QTR:  hit_o = (addr_ext >= QTR_BASE);
      PROT_HALF: hit_o = (addr_ext >= HALF_BASE);
      default:   hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wrg_protect_reg.sv
module wrg_protect_reg
  import wrg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [BP_W-1:0] data_i,
  output prot_code_e      bp_o
);
  prot_code_e bp_q;

  always_ff @(posedge clk) begin
    if (rst)         bp_q <= PROT_NONE;
    else if (load_i) bp_q <= prot_code_e'(data_i);
  end

  assign bp_o = bp_q;

  // R6
  bp_hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(bp_q));
endmodule

// File: rtl/status_wr_guard.sv
module status_wr_guard
  import wrg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en_i,
  input  logic              clr_en_i,
  input  logic              sr_wr_i,
  input  logic [STAT_W-1:0] sr_data_i,
  input  logic              mem_wr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              wp_n_i,
  input  logic              frame_end_i,
  output logic              mem_grant_o,
  output logic              sr_grant_o,
  output logic [STAT_W-1:0] status_o
);
  logic       wel;
  logic       in_range;
  logic       tier_ok;
  prot_code_e bp;
  logic       unused_sr_bits;

  assign unused_sr_bits = ^{sr_data_i[STAT_W-1:BP_MSB+1], sr_data_i[BP_LSB-1:0]};

  wrg_enable_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .set_i      (set_en_i),
    .clr_i      (clr_en_i),
    .wr_req_i   (mem_wr_i | sr_wr_i),
    .frame_end_i(frame_end_i),
    .wel_o      (wel)
  );

  wrg_protect_reg u_bp (
    .clk   (clk),
    .rst   (rst),
    .load_i(sr_grant_o),
    .data_i(sr_data_i[BP_MSB:BP_LSB]),
    .bp_o  (bp)
  );

  wrg_range_check #(.ADDR_W(ADDR_W)) u_range (
    .addr_i(mem_addr_i),
    .code_i(bp),
    .hit_o (in_range)
  );

  // first two tiers common to both write kinds
  assign tier_ok     = wel & wp_n_i;
  assign sr_grant_o  = sr_wr_i & tier_ok;
  assign mem_grant_o = mem_wr_i & tier_ok & ~in_range;

  // status byte assembled bit by bit, fixed positions tied low
  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == WEL_POS) begin : g_wel
      assign status_o[b] = wel;
    end else if (b >= BP_LSB && b <= BP_MSB) begin : g_bp
      assign status_o[b] = bp[b-BP_LSB];
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end

  // R4 R5
  mem_grant_tiers_chk: assert property (@(posedge clk) disable iff (rst)
    mem_grant_o |-> (wp_n_i && status_o[WEL_POS]));

  // R4 R5
  sr_grant_tiers_chk: assert property (@(posedge clk) disable iff (rst)
    sr_grant_o |-> (wp_n_i && status_o[WEL_POS]));

  // R8
  mem_grant_not_all_chk: assert property (@(posedge clk) disable iff (rst)
    mem_grant_o |-> (status_o[BP_MSB:BP_LSB] != 2'b11));

  // R6
  sr_write_keeps_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_grant_o && !set_en_i && !clr_en_i && !frame_end_i) |=> $stable(status_o[WEL_POS]));
endmodule

// File: tb/test_status_wr_guard.sv
`timescale 1ns/1ps
module test_status_wr_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       set_en = 0, clr_en = 0, sr_wr = 0, mem_wr = 0, fe = 0;
  logic       wp_n = 1'b1;
  logic [7:0] sr_data = '0;
  logic [8:0] addr = '0;
  logic       mem_g, sr_g;
  logic [7:0] stat;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural model state
  bit       m_wel = 0;
  bit       m_seen = 0;
  int       m_bp = 0;

  always #2 clk = ~clk;

  status_wr_guard i_status_wr_guard (
    .clk(clk), .rst(rst), .set_en_i(set_en), .clr_en_i(clr_en),
    .sr_wr_i(sr_wr), .sr_data_i(sr_data), .mem_wr_i(mem_wr),
    .mem_addr_i(addr), .wp_n_i(wp_n), .frame_end_i(fe),
    .mem_grant_o(mem_g), .sr_grant_o(sr_g), .status_o(stat));

  function automatic bit model_prot(int a, int code);
    case (code)
      0: return 0;
      1: return a >= 384;
      2: return a >= 256;
      default: return 1;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: drive, compare at falling edge, update model after rising edge
  task automatic step(string tag, bit s, bit c, bit sw, int sd, bit mw, int a, bit fend);
    bit e_mem, e_sr, any;
    int exp_stat;
    set_en = s; clr_en = c; sr_wr = sw; sr_data = 8'(sd);
    mem_wr = mw; addr = 9'(a); fe = fend;
    @(negedge clk);
    e_sr  = sw && m_wel && wp_n;
    e_mem = mw && m_wel && wp_n && !model_prot(a, m_bp);
    exp_stat = m_bp * 4 + (m_wel ? 2 : 0);
    chk(tag, "mem_grant", int'(mem_g), int'(e_mem));
    chk(tag, "sr_grant", int'(sr_g), int'(e_sr));
    chk(tag, "status", int'(stat), exp_stat);
    @(posedge clk);
    any = m_seen || sw || mw;
    if (e_sr) m_bp = (sd / 4) % 4;
    if (fend && any) m_wel = 0;
    else if (c)      m_wel = 0;
    else if (s)      m_wel = 1;
    m_seen = fend ? 0 : any;
    #1;
  endtask

  task automatic idle(string tag);          step(tag, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wren(string tag);          step(tag, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic wrdi(string tag);          step(tag, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic srw(string tag, int d);    step(tag, 0, 0, 1, d, 0, 0, 0); endtask
  task automatic memw(string tag, int a);   step(tag, 0, 0, 0, 0, 1, a, 0); endtask
  task automatic fend(string tag);          step(tag, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    idle("R1");
    // R4: latch clear refuses both writes and keeps protect field
    memw("R4", 0); srw("R4", 8'h0C); fend("R4"); idle("R4");
    // R2: set, clear, and coincident set with clear
    wren("R2"); idle("R2"); wrdi("R2"); idle("R2");
    wren("R2"); step("R2", 1, 1, 0, 0, 0, 0, 0); idle("R2");
    // R5: pin low blocks everything even with latch set
    wren("R5"); wp_n = 1'b0;
    srw("R5", 8'h0C); memw("R5", 5); fend("R5"); idle("R5");
    wp_n = 1'b1;
    // R3 R6: ones in fixed positions ignored; latch unchanged by status write
    wren("R6"); srw("R3", 8'hFF); idle("R3"); idle("R6");
    // R7: frame end with write clears latch
    fend("R7"); idle("R7");
    // R7: frame end without write keeps latch
    wren("R7"); fend("R7"); idle("R7");
    // R7: write arriving together with frame end still clears
    step("R7", 0, 0, 0, 0, 1, 3, 1); idle("R7");
    // R8 R9: each protect code against boundary addresses
    for (int code = 0; code < 4; code++) begin
      wren("R8"); srw("R8", code * 4 + 8'hF1); fend("R8");
      wren("R8");
      memw("R8", 9'h17F); memw("R8", 9'h180); memw("R8", 9'h0FF);
      memw("R8", 9'h100); memw("R9", 9'h1FF); memw("R9", 9'h000);
      fend("R8"); idle("R8");
    end
    // R9: burst across protected range and wrap, code 01
    wren("R9"); srw("R9", 8'h04); fend("R9");
    wren("R9");
    for (int a = 9'h17D; a < 9'h17D + 8; a++) memw("R9", a % 512);
    memw("R9", 9'h1FF); memw("R9", 9'h000); memw("R9", 9'h001);
    fend("R9"); idle("R9");
    // R10: write in same cycle as enable judged on old latch
    step("R10", 1, 0, 0, 0, 1, 2, 0); memw("R10", 2);
    step("R10", 1, 0, 1, 8'h08, 0, 0, 0); fend("R10"); idle("R10");
    // R10: status write together with enable while latch clear
    step("R10", 1, 0, 1, 8'h0C, 0, 0, 0); idle("R10"); fend("R10"); idle("R10");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule